// File: doc/BRIEF.md
# Segment Address Translator with Protection

This block turns a logical address, made of a segment number and an offset inside that segment, into a physical address. It holds a small table of segment descriptors. Each descriptor carries a base, a limit, a present flag and three access flags: read allowed, write allowed, and reachable from user mode. A request names a segment, an offset, the access direction and the mode of the requester. The block returns either the physical address, which is the base plus the offset, or a fault with a cause code. It decides this in a single cycle, before any memory access is made.

The descriptor table is loaded through a write port. A write only takes effect when the requester is in system mode. A write made in user mode leaves the table as it was and raises a privilege fault strobe. All outputs are registered, so a request gets its answer one clock later.

Top module: `seg_translator`

## Requirements
- R1: After synchronous reset, `rsp_valid` and `priv_fault` are 0 and every descriptor is marked not present. A request made after reset, before any table write, returns fault cause 1.
- R2: `rsp_valid` is high in the cycle right after a cycle with `req_valid` high, and low otherwise. The response describes that earlier request.
- R3: A request with no fault returns cause 0 and `rsp_paddr` = base + zero-extended offset, taken modulo 2^24.
- R4: An offset greater than or equal to the descriptor's limit returns cause 2. A limit of 0 therefore faults on every offset.
- R5: A descriptor that is not present returns cause 1, whatever its other fields hold.
- R6: A read needs the read flag and a write needs the write flag. A request in user mode also needs the user flag, and a request in system mode ignores that flag. A failed check returns cause 3.
- R7: When several faults apply, cause 1 has priority over cause 2, and cause 2 has priority over cause 3.
- R8: A table write in system mode replaces the indexed descriptor. A request in the same cycle as the write still sees the old descriptor. A request in any later cycle sees the new one.
- R9: A table write in user mode leaves the table unchanged. `priv_fault` is then high for exactly the next cycle. It is low after every other cycle.
- R10: A faulting response drives `rsp_paddr` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Translation request present |
| req_seg | input | 3 | Segment number |
| req_off | input | 16 | Offset within the segment |
| req_write | input | 1 | 1 = write access, 0 = read access |
| user_mode | input | 1 | 1 = user mode, 0 = system mode (applies to requests and table writes) |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | 3 | Descriptor index to write |
| tbl_base | input | 24 | New base |
| tbl_limit | input | 16 | New limit |
| tbl_present | input | 1 | New present flag |
| tbl_read | input | 1 | New read-allowed flag |
| tbl_write | input | 1 | New write-allowed flag |
| tbl_user | input | 1 | New user-reachable flag |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 24 | Physical address, or 0 on a fault |
| rsp_fault | output | 2 | Cause: 0 none, 1 not present, 2 limit, 3 permission |
| priv_fault | output | 1 | Pulse after a table write rejected in user mode |

## Verification
The assertions check four things on every cycle:
- the one-cycle response timing;
- the privilege strobe that follows a user-mode table write;
- the zero address on faulting responses;
- that the cause the checker reports matches the present flag and the limit of the descriptor being read.

Other behaviour only shows up in the bench's scenarios. These scenarios cover:
- the arithmetic of the physical address, including wrap past 2^24;
- the boundary between an offset of limit−1 and an offset equal to the limit;
- the interplay of the permission flags with mode;
- fault priority;
- whether a write in the same cycle as a request is seen, and whether a rejected write really left the table untouched.

// File: rtl/segx_pkg.sv
package segx_pkg;
    localparam int SEG_W  = 3;
    localparam int OFF_W  = 16;
    localparam int BASE_W = 24;
    localparam int LIM_W  = 16;
    localparam int NSEG   = 1 << SEG_W;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_ABSENT  = 2'd1,
        FLT_LIMIT   = 2'd2,
        FLT_PERM    = 2'd3
    } fault_e;

    typedef struct packed {
        logic              present;
        logic              can_read;
        logic              can_write;
        logic              user_ok;
        logic [LIM_W-1:0]  limit;
        logic [BASE_W-1:0] base;
    } seg_desc_t;

    typedef struct packed {
        logic              valid;
        fault_e            fault;
        logic [BASE_W-1:0] paddr;
    } xlate_rsp_t;

    // Access rights check, independent of limit and presence.
    function automatic logic rights_ok(seg_desc_t d, logic is_write, logic is_user);
        logic dir_ok;
        dir_ok = is_write ? d.can_write : d.can_read;
        return dir_ok && (!is_user || d.user_ok);
    endfunction
endpackage

// File: rtl/seg_table.sv
module seg_table
    import segx_pkg::*;
#(
    parameter int ENTRIES = NSEG,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  seg_desc_t        wr_desc,
    input  logic [IDX_W-1:0] rd_idx,
    output seg_desc_t        rd_desc
);
    seg_desc_t slots [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                slots[g] <= wr_desc;
            end
        end
    end

    assign rd_desc = slots[rd_idx];
endmodule

// File: rtl/seg_check.sv
module seg_check
    import segx_pkg::*;
(
    input  seg_desc_t          desc,
    input  logic [OFF_W-1:0]   offset,
    input  logic               is_write,
    input  logic               is_user,
    output fault_e             fault,
    output logic [BASE_W-1:0]  paddr
);
    logic over_limit;
    logic [BASE_W-1:0] sum;

    assign over_limit = ({1'b0, offset} >= {1'b0, desc.limit});
    assign sum        = desc.base + BASE_W'(offset);

    always_comb begin
        if (!desc.present) begin
            fault = FLT_ABSENT;
        end else if (over_limit) begin
            fault = FLT_LIMIT;
        end else if (!rights_ok(desc, is_write, is_user)) begin
            fault = FLT_PERM;
        end else begin
            fault = FLT_NONE;
        end
        paddr = (fault == FLT_NONE) ? sum : '0;
    end
endmodule

// File: rtl/seg_translator.sv
module seg_translator
    import segx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic              req_write,
    input  logic              user_mode,
    input  logic              tbl_we,
    input  logic [SEG_W-1:0]  tbl_idx,
    input  logic [BASE_W-1:0] tbl_base,
    input  logic [LIM_W-1:0]  tbl_limit,
    input  logic              tbl_present,
    input  logic              tbl_read,
    input  logic              tbl_write,
    input  logic              tbl_user,
    output logic              rsp_valid,
    output logic [BASE_W-1:0] rsp_paddr,
    output logic [1:0]        rsp_fault,
    output logic              priv_fault
);
    seg_desc_t  new_desc, cur_desc;
    fault_e     chk_fault;
    logic [BASE_W-1:0] chk_paddr;
    logic       sys_write, denied_write;
    xlate_rsp_t rsp_q;

    assign sys_write    = tbl_we && !user_mode;
    assign denied_write = tbl_we &&  user_mode;

    always_comb begin
        new_desc.present   = tbl_present;
        new_desc.can_read  = tbl_read;
        new_desc.can_write = tbl_write;
        new_desc.user_ok   = tbl_user;
        new_desc.limit     = tbl_limit;
        new_desc.base      = tbl_base;
    end

    seg_table #(.ENTRIES(NSEG)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (sys_write),
        .wr_idx  (tbl_idx),
        .wr_desc (new_desc),
        .rd_idx  (req_seg),
        .rd_desc (cur_desc)
    );

    seg_check u_check (
        .desc     (cur_desc),
        .offset   (req_off),
        .is_write (req_write),
        .is_user  (user_mode),
        .fault    (chk_fault),
        .paddr    (chk_paddr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q      <= '0;
            priv_fault <= 1'b0;
        end else begin
            priv_fault  <= denied_write;
            rsp_q.valid <= req_valid;
            rsp_q.fault <= req_valid ? chk_fault : FLT_NONE;
            rsp_q.paddr <= req_valid ? chk_paddr : '0;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_fault = rsp_q.fault;
    assign rsp_paddr = rsp_q.paddr;

    // R2: response one cycle after request
    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    // R9: rejected table write strobes privilege fault
    a_r9_priv_strobe: assert property (@(posedge clk) disable iff (rst)
        (tbl_we && user_mode) |=> priv_fault);
    a_r9_priv_quiet: assert property (@(posedge clk) disable iff (rst)
        !(tbl_we && user_mode) |=> !priv_fault);
    // R10: faulting response carries no address
    a_r10_fault_no_addr: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));
    // R5 / R7: absent descriptor wins over every other cause
    a_r5_absent_first: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !cur_desc.present) |-> (chk_fault == FLT_ABSENT));
    // R4 / R7: limit fault outranks permission on a present descriptor
    a_r4_limit_next: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cur_desc.present && (req_off >= cur_desc.limit))
            |-> (chk_fault == FLT_LIMIT));
endmodule

// File: tb/seg_translator_test.sv
module seg_translator_test;
    logic clk = 1'b0;
    logic rst;
    logic req_valid, req_write, user_mode, tbl_we;
    logic [2:0] req_seg, tbl_idx;
    logic [15:0] req_off, tbl_limit;
    logic [23:0] tbl_base;
    logic tbl_present, tbl_read, tbl_write, tbl_user;
    logic rsp_valid, priv_fault;
    logic [23:0] rsp_paddr;
    logic [1:0] rsp_fault;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // bench model of the table
    logic [23:0] m_base [8];
    logic [15:0] m_lim  [8];
    logic        m_pr [8], m_rd [8], m_wr [8], m_us [8];

    always #5 clk = ~clk;

    seg_translator uut (.*);

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_fault(int s, logic [15:0] off, logic w, logic u);
        if (!m_pr[s]) return 2'd1;
        if (off >= m_lim[s]) return 2'd2;
        if (w ? !m_wr[s] : !m_rd[s]) return 2'd3;
        if (u && !m_us[s]) return 2'd3;
        return 2'd0;
    endfunction

    function automatic logic [23:0] exp_addr(int s, logic [15:0] off, logic w, logic u);
        if (exp_fault(s, off, w, u) != 2'd0) return 24'd0;
        return m_base[s] + {8'd0, off};
    endfunction

    // one cycle: drive at negedge, check the registered result at the next negedge
    task automatic step(input string req,
                        input logic rv, input int s, input logic [15:0] off,
                        input logic w, input logic u,
                        input logic we, input int wi, input logic [23:0] b,
                        input logic [15:0] l, input logic [3:0] flags);
        logic [1:0]  ef;
        logic [23:0] ea;
        req_valid = rv; req_seg = 3'(s); req_off = off; req_write = w; user_mode = u;
        tbl_we = we; tbl_idx = 3'(wi); tbl_base = b; tbl_limit = l;
        {tbl_present, tbl_read, tbl_write, tbl_user} = flags;
        ef = exp_fault(s, off, w, u);
        ea = exp_addr(s, off, w, u);
        @(posedge clk);
        if (we && !u) begin
            m_base[wi] = b; m_lim[wi] = l;
            {m_pr[wi], m_rd[wi], m_wr[wi], m_us[wi]} = flags;
        end
        @(negedge clk);
        chk({"R2 ", req}, 32'(rsp_valid), 32'(rv));
        if (rv) begin
            chk({"R7 fault ", req}, 32'(rsp_fault), 32'(ef));
            chk({"R3/R10 paddr ", req}, 32'(rsp_paddr), 32'(ea));
        end
        chk({"R9 strobe ", req}, 32'(priv_fault), 32'(we && u));
    endtask

    task automatic rd(input string req, input int s, input logic [15:0] off,
                      input logic w, input logic u);
        step(req, 1'b1, s, off, w, u, 1'b0, 0, 24'd0, 16'd0, 4'd0);
    endtask

    task automatic wt(input string req, input logic u, input int wi, input logic [23:0] b,
                      input logic [15:0] l, input logic [3:0] flags);
        step(req, 1'b0, 0, 16'd0, 1'b0, 1'b0, 1'b1, wi, b, l, flags);
        if (u) begin end
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 8; i++) begin
            m_base[i] = '0; m_lim[i] = '0;
            m_pr[i] = 0; m_rd[i] = 0; m_wr[i] = 0; m_us[i] = 0;
        end
        rst = 1'b1; req_valid = 0; req_seg = 0; req_off = 0; req_write = 0;
        user_mode = 0; tbl_we = 0; tbl_idx = 0; tbl_base = 0; tbl_limit = 0;
        {tbl_present, tbl_read, tbl_write, tbl_user} = 4'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        chk("R1 priv_fault after reset", 32'(priv_fault), 32'd0);
        rst = 1'b0;

        // R1: everything absent after reset
        for (int s = 0; s < 8; s++) rd("R1 absent after reset", s, 16'h0, 1'b0, 1'b0);

        // R3 / R4: limit boundary, flags {present,read,write,user}
        wt("R8 load seg1", 1'b0, 1, 24'h001000, 16'h0100, 4'b1111);
        rd("R3 last in-range offset", 1, 16'h00FF, 1'b0, 1'b1);
        rd("R4 offset equal to limit", 1, 16'h0100, 1'b0, 1'b1);
        // R4: zero limit always faults
        wt("R8 load seg2 zero limit", 1'b0, 2, 24'h000500, 16'h0000, 4'b1111);
        rd("R4 zero limit", 2, 16'h0000, 1'b0, 1'b0);
        // R3: address wraps modulo 2^24
        wt("R8 load seg3 high base", 1'b0, 3, 24'hFFFFF0, 16'hFFFF, 4'b1110);
        rd("R3 wrap", 3, 16'h0020, 1'b1, 1'b0);
        // R6: system mode ignores user flag, user mode needs it
        rd("R6 user denied", 3, 16'h0020, 1'b0, 1'b1);
        // R6: direction flags
        wt("R8 load seg4 read only", 1'b0, 4, 24'h020000, 16'h8000, 4'b1101);
        rd("R6 read allowed", 4, 16'h0010, 1'b0, 1'b1);
        rd("R6 write denied", 4, 16'h0010, 1'b1, 1'b0);
        // R7: limit outranks permission; absent outranks limit
        rd("R7 limit over perm", 4, 16'h9000, 1'b1, 1'b0);
        wt("R8 load seg5 absent", 1'b0, 5, 24'h030000, 16'h0000, 4'b0000);
        rd("R5/R7 absent over limit and perm", 5, 16'hFFFF, 1'b1, 1'b1);
        // R9: user-mode write ignored; state brought out by a read
        step("R9 user write", 1'b0, 0, 16'd0, 1'b0, 1'b1, 1'b1, 1, 24'hABCDEF, 16'hFFFF, 4'b0000);
        rd("R9 table untouched", 1, 16'h0080, 1'b0, 1'b0);
        chk("R9 strobe single cycle", 32'(priv_fault), 32'd0);
        // R8: same-cycle write and request sees old descriptor
        step("R8 same-cycle old", 1'b1, 1, 16'h0010, 1'b0, 1'b0,
             1'b1, 1, 24'h200000, 16'h0020, 4'b1111);
        rd("R8 next cycle new", 1, 16'h0010, 1'b0, 1'b0);

        // random mix
        for (int i = 0; i < 600; i++) begin
            int s = int'($urandom_range(0, 7));
            logic [15:0] lim, off;
            lim = ($urandom_range(0, 1) != 0) ? 16'($urandom_range(0, 64)) : 16'($urandom);
            off = ($urandom_range(0, 1) != 0) ? 16'($urandom_range(0, 70)) : 16'($urandom);
            step("R3/R4/R6 random", $urandom_range(0, 3) != 0, s, off,
                 1'($urandom), 1'($urandom),
                 $urandom_range(0, 3) == 0, int'($urandom_range(0, 7)),
                 24'($urandom), lim, 4'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule